// File: doc/BRIEF.md
# Grouped Channel Interrupt Collector with Periodic Tick

This block collects service requests from up to four groups of serial channels, eight channels per group. Each channel's request bit is registered into a per-group pending register. A controller-level summary register shows which enabled groups have at least one request. The summary and the tick source drive a single latched interrupt line toward the host. The host reads and writes a small register file through a plain address/data port.

A programmable periodic tick is built into the block. It divides the input clock into one of six doubling rates and raises a sticky tick-pending flag. The tick can run alongside channel interrupts. In periodic-only operation it replaces them as the sole source of the host line. The interrupt latch and the tick flag stay set until the host writes the end-of-interrupt bit.

A parameter selects the summary layout. In the legacy layout only group bits appear. In the extended layout the tick flag is also shown in summary bit 4.

Top module: `chan_irq_agg`

## Requirements
- R1: Register address 4+g reads group g's pending byte, where bit i reflects channel i of that group (input bit g*8+i), one clock after the input. The byte reads zero while group g's enable bit is clear.
- R2: The summary register (address 2) has bit g set exactly when group g is enabled and its pending byte is nonzero. Group enables are bits 0..3 of address 1. In the legacy layout, summary bits 4 to 7 always read zero.
- R3: In the extended layout, summary bit 4 equals the tick-pending flag. Bits 5 to 7 read zero.
- R4: The rate code is control register (address 0) bits 6:4. For codes 1 to 6, a tick occurs every TICK_BASE_CYCLES << (6 - code) clocks. Codes 0 and 7 produce no ticks.
- R5: A tick sets the tick-pending flag, which stays set until an end-of-interrupt write.
- R6: While control bit 7 (periodic-only) is set, channel requests do not set the interrupt latch. A pending tick still does.
- R7: The host line is low whenever control bit 3 (master enable) is clear. When the bit is set, the line shows the interrupt latch.
- R8: Writing control with bit 2 set clears both the interrupt latch and the tick flag at that clock edge. Bit 2 always reads back as zero.
- R9: The latch sets one clock after the summary shows an enabled group request (outside periodic-only mode), or after the tick flag is set. It holds until an end-of-interrupt write, even if the requests go away.
- R10: After reset, every register reads zero and the host line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req_i | input | NUM_GROUPS*CHANS_PER_GROUP | Channel request levels, group-major |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| host_irq_o | output | 1 | Host interrupt line |

## Verification
A corrupted pending register shows up in the group readback one clock after the channel inputs change. A wrong group gate shows up in the summary register in the same cycle. A latch that drops early, or never clears, shows at the host line on the first clock after the source goes away or after the end-of-interrupt write. A prescaler that miscounts shows up as a tick-to-tick interval that differs from the expected power-of-two multiple of the base period. The bench measures that interval exactly for three rate codes.

// File: rtl/agg_pkg.sv
package agg_pkg;
   localparam int DATA_W   = 8;
   localparam int ADDR_W   = 3;
   localparam int MAX_GRP  = 4;
   localparam int RATE_TOP = 6;

   localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
   localparam logic [ADDR_W-1:0] A_GRP_EN  = 3'd1;
   localparam logic [ADDR_W-1:0] A_SUMMARY = 3'd2;

   localparam int B_PONLY   = 7;
   localparam int B_RATE_LO = 4;
   localparam int B_MEN     = 3;
   localparam int B_EOI     = 2;
   localparam int B_TICK    = 4;

   typedef struct packed {
      logic       ponly;
      logic [2:0] rate;
      logic       men;
   } ctrl_t;
endpackage

// File: rtl/agg_regs.sv
module agg_regs
   import agg_pkg::*;
#(
   parameter int NUM_GROUPS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     wr_addr_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   output ctrl_t                 ctrl_o,
   output logic [NUM_GROUPS-1:0] grp_en_o,
   output logic                  eoi_o
);
   logic ctrl_wr, en_wr;

   assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
   assign en_wr   = wr_en_i && (wr_addr_i == A_GRP_EN);
   assign eoi_o   = ctrl_wr && wr_data_i[B_EOI];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o   <= '0;
         grp_en_o <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl_o.ponly <= wr_data_i[B_PONLY];
            ctrl_o.rate  <= wr_data_i[B_RATE_LO +: 3];
            ctrl_o.men   <= wr_data_i[B_MEN];
         end
         if (en_wr)
            grp_en_o <= wr_data_i[NUM_GROUPS-1:0];
      end
   end

   AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(grp_en_o)); // R2
endmodule

// File: rtl/agg_group_bank.sv
module agg_group_bank #(
   parameter int NUM_GROUPS      = 4,
   parameter int CHANS_PER_GROUP = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [NUM_GROUPS*CHANS_PER_GROUP-1:0] req_i,
   input  logic [NUM_GROUPS-1:0]                 grp_en_i,
   output logic [NUM_GROUPS*CHANS_PER_GROUP-1:0] vis_o,
   output logic [NUM_GROUPS-1:0]                 active_o
);
   localparam int W = NUM_GROUPS*CHANS_PER_GROUP;

   logic [W-1:0] pend_q;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_q[g*CHANS_PER_GROUP +: CHANS_PER_GROUP] <= '0;
         else        pend_q[g*CHANS_PER_GROUP +: CHANS_PER_GROUP] <=
                        req_i[g*CHANS_PER_GROUP +: CHANS_PER_GROUP];
      end
      assign vis_o[g*CHANS_PER_GROUP +: CHANS_PER_GROUP] =
         grp_en_i[g] ? pend_q[g*CHANS_PER_GROUP +: CHANS_PER_GROUP] : '0;
      assign active_o[g] = grp_en_i[g] && (|pend_q[g*CHANS_PER_GROUP +: CHANS_PER_GROUP]);
   end

   AST_PEND_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> pend_q == $past(req_i)); // R1
endmodule

// File: rtl/agg_tick.sv
module agg_tick
   import agg_pkg::*;
#(
   parameter int TICK_BASE_CYCLES = 364964
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] rate_i,
   input  logic       eoi_i,
   output logic       flag_o
);
   localparam int MAX_P = TICK_BASE_CYCLES * 32;
   localparam int CW    = $clog2(MAX_P + 1);

   logic [CW-1:0] cnt_q, period;
   logic [2:0]    rate_seen_q;
   logic          active, tick;

   assign active = (rate_i != 3'd0) && (rate_i != 3'd7);

   always_comb begin
      period = '0;
      if (active)
         period = CW'(TICK_BASE_CYCLES) << (3'(RATE_TOP) - rate_i);
   end

   assign tick = active && (rate_i == rate_seen_q) && (cnt_q == period - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         rate_seen_q <= '0;
         flag_o      <= 1'b0;
      end else begin
         if (rate_i != rate_seen_q) begin
            rate_seen_q <= rate_i;
            cnt_q       <= '0;
         end else if (active) begin
            cnt_q <= tick ? '0 : cnt_q + CW'(1);
         end
         flag_o <= tick | (flag_o & ~eoi_i);
      end
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !eoi_i) |=> flag_o); // R5
   AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_i == 3'd0 || rate_i == 3'd7) |-> !tick); // R4
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(MAX_P)); // R4
endmodule

// File: rtl/chan_irq_agg.sv
module chan_irq_agg
   import agg_pkg::*;
#(
   parameter int NUM_GROUPS       = 4,
   parameter int CHANS_PER_GROUP  = 8,
   parameter int TICK_BASE_CYCLES = 364964,
   parameter bit TICK_IN_SUMMARY  = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [NUM_GROUPS*CHANS_PER_GROUP-1:0] chan_req_i,
   input  logic                                  wr_en_i,
   input  logic [2:0]                            wr_addr_i,
   input  logic [7:0]                            wr_data_i,
   input  logic [2:0]                            rd_addr_i,
   output logic [7:0]                            rd_data_o,
   output logic                                  host_irq_o
);
   localparam int W = NUM_GROUPS*CHANS_PER_GROUP;

   initial begin
      if (NUM_GROUPS < 1 || NUM_GROUPS > MAX_GRP)
         $fatal(1, "NUM_GROUPS out of range");
      if (CHANS_PER_GROUP < 1 || CHANS_PER_GROUP > DATA_W)
         $fatal(1, "CHANS_PER_GROUP out of range");
      if (TICK_BASE_CYCLES < 2)
         $fatal(1, "TICK_BASE_CYCLES too small");
   end

   ctrl_t                 ctrl;
   logic [NUM_GROUPS-1:0] grp_en, active;
   logic [W-1:0]          vis;
   logic                  eoi, tick_flag, irq_latch, chan_any;
   logic [DATA_W-1:0]     summary;

   agg_regs #(.NUM_GROUPS(NUM_GROUPS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .ctrl_o(ctrl), .grp_en_o(grp_en), .eoi_o(eoi));

   agg_group_bank #(.NUM_GROUPS(NUM_GROUPS), .CHANS_PER_GROUP(CHANS_PER_GROUP)) u_bank (
      .clk(clk), .rst_n(rst_n), .req_i(chan_req_i), .grp_en_i(grp_en),
      .vis_o(vis), .active_o(active));

   agg_tick #(.TICK_BASE_CYCLES(TICK_BASE_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .rate_i(ctrl.rate), .eoi_i(eoi), .flag_o(tick_flag));

   assign chan_any = |active;

   if (TICK_IN_SUMMARY) begin : g_ext_sum
      always_comb begin
         summary = '0;
         summary[NUM_GROUPS-1:0] = active;
         summary[B_TICK] = tick_flag;
      end
   end else begin : g_leg_sum
      always_comb begin
         summary = '0;
         summary[NUM_GROUPS-1:0] = active;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   irq_latch <= 1'b0;
      else if (eoi) irq_latch <= 1'b0;
      else if ((chan_any && !ctrl.ponly) || tick_flag) irq_latch <= 1'b1;
   end

   assign host_irq_o = irq_latch && ctrl.men;

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         A_CTRL:    rd_data_o = {ctrl.ponly, ctrl.rate, ctrl.men, 3'b000};
         A_GRP_EN:  rd_data_o[NUM_GROUPS-1:0] = grp_en;
         A_SUMMARY: rd_data_o = summary;
         default: begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
               if (rd_addr_i[2] && (int'(rd_addr_i[1:0]) == g))
                  rd_data_o[CHANS_PER_GROUP-1:0] = vis[g*CHANS_PER_GROUP +: CHANS_PER_GROUP];
            end
         end
      endcase
   end

   AST_EOI_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      eoi |=> !irq_latch); // R8
   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_latch && !eoi) |=> irq_latch); // R9
   AST_PONLY_BLOCKS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.ponly && !tick_flag && !irq_latch && !eoi) |=> !irq_latch); // R6
endmodule

// File: tb/tb_chan_irq_agg.sv
`timescale 1ns/1ps
module tb_chan_irq_agg;
   localparam int NG = 4, CH = 8, BASE = 16;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [NG*CH-1:0] chan_req = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0, rd_addr = '0;
   logic [7:0]    wr_data = '0, rd_data, rd_data_lg;
   logic          irq, irq_lg;
   int            checks = 0, errors = 0;
   bit            done = 0;

   always #2.5 clk = ~clk;

   chan_irq_agg #(.NUM_GROUPS(NG), .CHANS_PER_GROUP(CH), .TICK_BASE_CYCLES(BASE),
                  .TICK_IN_SUMMARY(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .chan_req_i(chan_req), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data), .host_irq_o(irq));

   chan_irq_agg #(.NUM_GROUPS(NG), .CHANS_PER_GROUP(CH), .TICK_BASE_CYCLES(BASE),
                  .TICK_IN_SUMMARY(1'b0)) dut_lg (
      .clk(clk), .rst_n(rst_n), .chan_req_i(chan_req), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
      .rd_data_o(rd_data_lg), .host_irq_o(irq_lg));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      rd_addr = a; #0.5; v = int'(rd_data);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      int v;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v); chk("R10 reg after reset", v, 0);
      end
      chk("R10 irq after reset", int'(irq), 0);
   endtask

   task automatic t_groups();
      int v;
      wr(3'd1, 8'h0F);
      chan_req = '0; chan_req[2*8 +: 8] = 8'hA5; chan_req[0] = 1'b1;
      @(negedge clk);
      rd(3'd6, v); chk("R1 group2 byte", v, 'hA5);
      rd(3'd4, v); chk("R1 group0 byte", v, 'h01);
      rd(3'd5, v); chk("R1 group1 empty", v, 0);
      rd(3'd2, v); chk("R2 summary two groups", v, 'h05);
      wr(3'd1, 8'h0B);
      rd(3'd6, v); chk("R1 disabled group reads zero", v, 0);
      rd(3'd2, v); chk("R2 disabled group gated", v, 'h01);
      rd(3'd1, v); chk("R2 enable readback", v, 'h0B);
   endtask

   task automatic t_latch();
      int v;
      chk("R7 line low without master enable", int'(irq), 0);
      wr(3'd0, 8'h08);
      chk("R7 line high after master enable", int'(irq), 1);
      chan_req = '0; idle(4);
      chk("R9 latch holds after request drops", int'(irq), 1);
      wr(3'd0, 8'h0C);
      chk("R8 eoi clears line", int'(irq), 0);
      rd(3'd0, v); chk("R8 eoi bit reads zero", v, 'h08);
      idle(3);
      chk("R8 line stays clear", int'(irq), 0);
      chan_req[1] = 1'b1;
      @(negedge clk);
      chk("R9 not yet set after one edge", int'(irq), 0);
      @(negedge clk);
      chk("R9 set after two edges", int'(irq), 1);
      wr(3'd0, 8'h00);
      chk("R7 master enable cleared", int'(irq), 0);
   endtask

   task automatic t_ponly();
      int v;
      wr(3'd0, 8'h8C);
      idle(6);
      chk("R6 channel request blocked", int'(irq), 0);
      rd(3'd2, v); chk("R6 summary still shows group", v, 'h01);
      wr(3'd0, 8'hE8);
      idle(40);
      chk("R6 tick still raises line", int'(irq), 1);
      rd(3'd2, v); chk("R3 summary tick bit", v, 'h11);
      rd_addr = 3'd2; #0.5;
      chk("R2 legacy summary hides tick", int'(rd_data_lg), 'h01);
      chan_req = '0;
   endtask

   task automatic t_period(input int code);
      int n; bit seen;
      wr(3'd0, 8'((code << 4) | 4));
      rd_addr = 3'd2;
      seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
         @(negedge clk); #0.5; seen = rd_data[4];
      end
      chk($sformatf("R4 first tick code %0d", code), int'(seen), 1);
      wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'((code << 4) | 4);
      n = 0; seen = 0;
      while (!seen && n < 2000) begin
         @(negedge clk); n++; wr_en = 1'b0; #0.5; seen = rd_data[4];
      end
      chk($sformatf("R4 period code %0d", code), n, BASE << (6 - code));
   endtask

   task automatic t_sticky();
      int v;
      idle(100);
      rd(3'd2, v); chk("R5 flag sticky", v & 'h10, 'h10);
      wr(3'd0, 8'h14);
      rd(3'd2, v); chk("R5 flag cleared by eoi", v & 'h10, 0);
   endtask

   task automatic t_off(input int code);
      int v;
      wr(3'd0, 8'((code << 4) | 4));
      idle(600);
      rd(3'd2, v); chk($sformatf("R4 no tick code %0d", code), v, 0);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_groups();
      t_latch();
      t_ponly();
      t_period(6);
      t_period(5);
      t_period(1);
      t_sticky();
      t_off(0);
      t_off(7);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule